// File: doc/BRIEF.md
# NaN Classifier and Quieter

This block takes one floating-point operand in one of four interchange formats and reports whether it is a NaN. If it is, the block also says whether the NaN is quiet or signaling. The four formats are binary16, bfloat16, binary32 and binary64. The operand sits right-aligned in a 64-bit bus, and a 2-bit select names the format.

The block also produces two values. The first is a quieted copy of the operand, which a datapath returns when it propagates a NaN. The second is the canonical default NaN for the selected format.

Two configuration inputs set the NaN convention:
- A polarity input decides what a set top fraction bit means. With polarity 0 it marks a quiet NaN; with polarity 1 it marks a signaling NaN.
- A no-signaling mode treats every NaN as quiet.

A parameter chooses between a purely combinational build and a build with one output register stage. The registered build moves a valid flag alongside the data.

Top module: `nan_screen`

## Requirements
- R1: `fmtSel` picks the format: 0 binary16 (5-bit exponent, 10-bit fraction), 1 bfloat16 (8, 7), 2 binary32 (8, 23), 3 binary64 (11, 52). The sign sits just above the exponent, and the fraction starts at bit 0.
- R2: `isNan` is 1 exactly when the exponent field is all ones and the fraction is nonzero. An all-ones exponent with a zero fraction (infinity) gives `isNan` 0.
- R3: With `sigPolarity` 0 and `noSignaling` 0, a NaN whose top fraction bit is 1 is quiet. A NaN whose top fraction bit is 0 (and whose lower fraction is nonzero) is signaling.
- R4: With `sigPolarity` 1 and `noSignaling` 0, a NaN whose top fraction bit is 1 is signaling. A NaN whose top fraction bit is 0 and whose lower fraction bits are nonzero is quiet.
- R5: With `noSignaling` 1, every NaN reports `isQuiet` 1 and `isSignaling` 0. Under this mode `quietedOut` equals the operand.
- R6: With polarity 0, quieting a signaling NaN sets the top fraction bit and leaves all other bits as they were.
- R7: With polarity 1, quieting a signaling NaN clears the top fraction bit, sets the fraction bit just below it, and leaves all other bits as they were.
- R8: For any operand that is not a signaling NaN, `quietedOut` equals the operand. Bits above the selected format's width are ignored by classification and are zero in `quietedOut`.
- R9: `defaultNanOut` has sign 0 and an all-ones exponent. Its fraction has only the top bit set under polarity 0, and every bit except the top one set under polarity 1. Bits above the format width are 0.
- R10: `isQuiet` and `isSignaling` are never both 1, and `isNan` equals their OR.
- R11: With `OUT_REG`=1, every output appears one clock after the inputs are sampled, and `validOut` is `validIn` delayed one cycle. An active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when OUT_REG=1) |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operand valid |
| fmtSel | input | 2 | Format select (R1 encoding) |
| operandIn | input | 64 | Right-aligned operand |
| sigPolarity | input | 1 | 0: set top fraction bit means quiet; 1: it means signaling |
| noSignaling | input | 1 | Treat every NaN as quiet |
| validOut | output | 1 | Result valid |
| isNan | output | 1 | Operand is a NaN |
| isQuiet | output | 1 | Operand is a quiet NaN |
| isSignaling | output | 1 | Operand is a signaling NaN |
| quietedOut | output | 64 | Operand with a signaling NaN quieted |
| defaultNanOut | output | 64 | Default NaN for the selected format |

## Verification
The checker holds several properties on every valid cycle:
- the flag relations (exclusivity, and `isNan` as the OR of the other two);
- `isSignaling` staying low in no-signaling mode;
- `quietedOut` matching the operand whenever the operand is not signaling, and differing from it when it is;
- the exponent, sign and upper bits of the default NaN;
- the one-cycle valid latency.

Only the bench's sweeps can show that each flag and fraction bit is right for each format and polarity. They also cover the boundary between infinity and NaN, and the exact bits that quieting flips.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BRAIN  = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmtSel_e;

  typedef struct packed {
    logic    capture;
    fmtSel_e fmt;
    logic    polOne;
    logic    noSig;
  } ctlStrobes_t;

  function automatic int expWidth(fmtSel_e f);
    case (f)
      FMT_HALF:   return 5;
      FMT_BRAIN:  return 8;
      FMT_SINGLE: return 8;
      default:    return 11;
    endcase
  endfunction

  function automatic int fracWidth(fmtSel_e f);
    case (f)
      FMT_HALF:   return 10;
      FMT_BRAIN:  return 7;
      FMT_SINGLE: return 23;
      default:    return 52;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lowOnes(int n);
    return (n >= DATA_W) ? '1 : ((DATA_W'(1) << n) - DATA_W'(1));
  endfunction
endpackage

// File: rtl/nanq_ctrl.sv
module nanq_ctrl
  import nanq_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [1:0]  fmtSel,
  input  logic        sigPolarity,
  input  logic        noSignaling,
  output ctlStrobes_t ctl,
  output logic        validOut
);
  always_comb begin
    ctl.capture = validIn;
    ctl.fmt     = fmtSel_e'(fmtSel);
    ctl.polOne  = sigPolarity;
    ctl.noSig   = noSignaling;
  end

  generate
    if (OUT_REG) begin : gValidReg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= validIn;
      end
      assign validOut = validQ;
    end else begin : gValidComb
      assign validOut = validIn;
    end
  endgenerate
endmodule

// File: rtl/nanq_datapath.sv
module nanq_datapath
  import nanq_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] operandIn,
  output logic              isNan,
  output logic              isQuiet,
  output logic              isSignaling,
  output logic [DATA_W-1:0] quietedOut,
  output logic [DATA_W-1:0] defaultNanOut
);
  logic [DATA_W-1:0] expMask, topMask, nextMask, lowMask, widthMask, opW;
  logic expAllOnes, topSet, lowNonZero;
  logic nanC, sigC, quietC;
  logic [DATA_W-1:0] quietC64, dfltC64;

  always_comb begin
    int fw, ew;
    fw = fracWidth(ctl.fmt);
    ew = expWidth(ctl.fmt);
    topMask   = DATA_W'(1) << (fw - 1);
    nextMask  = DATA_W'(1) << (fw - 2);
    lowMask   = lowOnes(fw - 1);
    expMask   = lowOnes(ew) << fw;
    widthMask = lowOnes(fw + ew + 1);
    opW       = operandIn & widthMask;

    expAllOnes = (opW & expMask) == expMask;
    topSet     = |(opW & topMask);
    lowNonZero = |(opW & lowMask);

    nanC   = expAllOnes && (topSet || lowNonZero);
    sigC   = nanC && !ctl.noSig && (ctl.polOne ? topSet : !topSet);
    quietC = nanC && !sigC;

    if (!sigC)            quietC64 = opW;
    else if (ctl.polOne)  quietC64 = (opW & ~topMask) | nextMask;
    else                  quietC64 = opW | topMask;

    dfltC64 = expMask | (ctl.polOne ? lowMask : topMask);
  end

  generate
    if (OUT_REG) begin : gOutReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          isNan         <= 1'b0;
          isQuiet       <= 1'b0;
          isSignaling   <= 1'b0;
          quietedOut    <= '0;
          defaultNanOut <= '0;
        end else if (ctl.capture) begin
          isNan         <= nanC;
          isQuiet       <= quietC;
          isSignaling   <= sigC;
          quietedOut    <= quietC64;
          defaultNanOut <= dfltC64;
        end
      end
    end else begin : gOutComb
      assign isNan         = nanC;
      assign isQuiet       = quietC;
      assign isSignaling   = sigC;
      assign quietedOut    = quietC64;
      assign defaultNanOut = dfltC64;
    end
  endgenerate
endmodule

// File: rtl/nan_screen.sv
module nan_screen
  import nanq_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [1:0]  fmtSel,
  input  logic [63:0] operandIn,
  input  logic        sigPolarity,
  input  logic        noSignaling,
  output logic        validOut,
  output logic        isNan,
  output logic        isQuiet,
  output logic        isSignaling,
  output logic [63:0] quietedOut,
  output logic [63:0] defaultNanOut
);
  ctlStrobes_t ctl;

  nanq_ctrl #(.OUT_REG(OUT_REG)) uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .fmtSel(fmtSel),
    .sigPolarity(sigPolarity), .noSignaling(noSignaling),
    .ctl(ctl), .validOut(validOut)
  );

  nanq_datapath #(.OUT_REG(OUT_REG)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operandIn(operandIn),
    .isNan(isNan), .isQuiet(isQuiet), .isSignaling(isSignaling),
    .quietedOut(quietedOut), .defaultNanOut(defaultNanOut)
  );
endmodule

// File: rtl/nanq_checker.sv
module nanq_checker #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        validIn,
  input logic [1:0]  fmtSel,
  input logic [63:0] operandIn,
  input logic        sigPolarity,
  input logic        noSignaling,
  input logic        validOut,
  input logic        isNan,
  input logic        isQuiet,
  input logic        isSignaling,
  input logic [63:0] quietedOut,
  input logic [63:0] defaultNanOut
);
  logic [1:0]  dFmt;
  logic [63:0] dOp;
  logic        dNoSig;

  generate
    if (OUT_REG) begin : gDelay
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dFmt <= 2'd0; dOp <= '0; dNoSig <= 1'b0;
        end else if (validIn) begin
          dFmt <= fmtSel; dOp <= operandIn; dNoSig <= noSignaling;
        end
      end

      assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
        validOut == $past(validIn));
    end else begin : gNoDelay
      assign dFmt = fmtSel;
      assign dOp = operandIn;
      assign dNoSig = noSignaling;
    end
  endgenerate

  int chkFw, chkEw;
  logic [63:0] chkWidthMask, chkExpOnes;
  always_comb begin
    case (dFmt)
      2'd0: begin chkFw = 10; chkEw = 5;  end
      2'd1: begin chkFw = 7;  chkEw = 8;  end
      2'd2: begin chkFw = 23; chkEw = 8;  end
      default: begin chkFw = 52; chkEw = 11; end
    endcase
    chkWidthMask = (64'd1 << (chkFw + chkEw + 1)) - 64'd1;
    chkExpOnes   = (64'd1 << chkEw) - 64'd1;
  end

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isQuiet, isSignaling}));

  assert_nan_is_union_R10: assert property (@(posedge clk) disable iff (!rstN)
    isNan == (isQuiet | isSignaling));

  assert_no_signaling_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && dNoSig) |-> !isSignaling);

  assert_quieting_alters_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && isSignaling) |-> (quietedOut != (dOp & chkWidthMask)));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !isSignaling) |-> (quietedOut == (dOp & chkWidthMask)));

  assert_default_head_R9: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ((defaultNanOut >> chkFw) == chkExpOnes));
endmodule

bind nan_screen nanq_checker #(.OUT_REG(OUT_REG)) uChecker (
  .clk(clk), .rstN(rstN), .validIn(validIn), .fmtSel(fmtSel),
  .operandIn(operandIn), .sigPolarity(sigPolarity), .noSignaling(noSignaling),
  .validOut(validOut), .isNan(isNan), .isQuiet(isQuiet),
  .isSignaling(isSignaling), .quietedOut(quietedOut),
  .defaultNanOut(defaultNanOut)
);

// File: tb/tb_nan_screen.sv
module tb_nan_screen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic [63:0] operandIn = '0;
  logic        sigPolarity = 1'b0;
  logic        noSignaling = 1'b0;
  logic        validOut, isNan, isQuiet, isSignaling;
  logic [63:0] quietedOut, defaultNanOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nan_screen dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .fmtSel(fmtSel),
    .operandIn(operandIn), .sigPolarity(sigPolarity), .noSignaling(noSignaling),
    .validOut(validOut), .isNan(isNan), .isQuiet(isQuiet),
    .isSignaling(isSignaling), .quietedOut(quietedOut),
    .defaultNanOut(defaultNanOut)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int fw(input logic [1:0] f);
    return (f == 0) ? 10 : (f == 1) ? 7 : (f == 2) ? 23 : 52;
  endfunction
  function automatic int ew(input logic [1:0] f);
    return (f == 0) ? 5 : (f == 3) ? 11 : 8;
  endfunction

  // Apply one operand and compare against the bench's own model (R1 field layout)
  task automatic runVec(input logic [1:0] f, input logic [63:0] op, input logic p, input logic ns);
    int F, E;
    logic [63:0] wmask, frac, ex, allE, opw, top, low, expQ, expD;
    logic nan, sig, quiet;
    F = fw(f); E = ew(f);
    wmask = (64'd1 << (F + E + 1)) - 64'd1;
    opw   = op & wmask;
    frac  = opw & ((64'd1 << F) - 64'd1);
    allE  = (64'd1 << E) - 64'd1;
    ex    = (opw >> F) & allE;
    top   = (frac >> (F - 1)) & 64'd1;
    low   = frac & ((64'd1 << (F - 1)) - 64'd1);
    nan   = (ex == allE) && (frac != 0);
    sig   = !ns && nan && (p ? (top == 1) : (top == 0) && (low != 0));
    quiet = nan && !sig;
    if (!sig) expQ = opw;
    else if (p) expQ = (opw & ~(64'd1 << (F - 1))) | (64'd1 << (F - 2));
    else expQ = opw | (64'd1 << (F - 1));
    expD = (allE << F) | (p ? ((64'd1 << (F - 1)) - 64'd1) : (64'd1 << (F - 1)));

    @(negedge clk);
    fmtSel = f; operandIn = op; sigPolarity = p; noSignaling = ns; validIn = 1'b1;
    @(posedge clk);
    #1;
    checkEq("R11 validOut", {63'd0, validOut}, 64'd1);
    checkEq("R2 isNan", {63'd0, isNan}, {63'd0, nan});
    checkEq(ns ? "R5 isSignaling" : (p ? "R4 isSignaling" : "R3 isSignaling"),
            {63'd0, isSignaling}, {63'd0, sig});
    checkEq(ns ? "R5 isQuiet" : "R10 isQuiet", {63'd0, isQuiet}, {63'd0, quiet});
    checkEq(sig ? (p ? "R7 quietedOut" : "R6 quietedOut") : "R8 quietedOut", quietedOut, expQ);
    checkEq("R9 defaultNanOut", defaultNanOut, expD);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    checkEq("R11 reset validOut", {63'd0, validOut}, 64'd0);
    checkEq("R11 reset isNan", {63'd0, isNan}, 64'd0);
    checkEq("R11 reset quietedOut", quietedOut, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int cfg = 0; cfg < 4; cfg++) begin
      logic p, ns;
      p = cfg[0]; ns = cfg[1];
      // binary16: every encoding with an all-ones exponent, both signs (R2..R8)
      for (int s = 0; s < 2; s++)
        for (int fr = 0; fr < 1024; fr++)
          runVec(2'd0, (64'(s) << 15) | (64'h1F << 10) | 64'(fr), p, ns);
      // Other formats: top/next bit combinations over assorted low patterns
      for (int f = 1; f < 4; f++) begin
        int F, E;
        F = fw(2'(f)); E = ew(2'(f));
        for (int t = 0; t < 4; t++)
          for (int k = 0; k < 6; k++) begin
            logic [63:0] lowPat, op;
            lowPat = (k == 0) ? 64'd0 : (k == 1) ? 64'd1 :
                     ({$urandom, $urandom} & ((64'd1 << (F - 2)) - 64'd1));
            op = (((64'd1 << E) - 64'd1) << F) | (64'(t) << (F - 2)) | lowPat;
            if (k[0]) op = op | (64'd1 << (F + E));
            runVec(2'(f), op, p, ns);
          end
      end
      // Random operands, half forced into the NaN/infinity region; upper bits garbage (R8)
      for (int n = 0; n < 400; n++) begin
        logic [1:0] f;
        logic [63:0] op;
        f = 2'($urandom_range(0, 3));
        op = {$urandom, $urandom};
        if (n[0]) op = op | (((64'd1 << ew(f)) - 64'd1) << fw(f));
        runVec(f, op, p, ns);
      end
    end

    // R2: infinities in each format are not NaN
    for (int f = 0; f < 4; f++)
      runVec(2'(f), ((64'd1 << ew(2'(f))) - 64'd1) << fw(2'(f)), 1'b1, 1'b0);

    // R11: idle cycle drops validOut
    @(negedge clk);
    validIn = 1'b0;
    @(posedge clk);
    #1;
    checkEq("R11 idle validOut", {63'd0, validOut}, 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule